// File: doc/BRIEF.md
# Bidirectional Host/CPU Mailbox

This block carries single-word messages in both directions between an external host processor, attached through a parallel host port, and the on-chip CPU. Each side sees one mailbox location. A write there posts a word toward the other side, and a read there collects the word the other side posted. Two separate 16-bit holding registers keep the two directions apart. A pending flag per direction tracks whether the posted word has been collected.

The flags change only as side effects of mailbox accesses from the opposite side. There are no clear bits. A host write raises the inbound flag, and a CPU read drops it. A CPU write raises the outbound flag, and a host read drops it. A host read also latches a transmit-empty condition, which stays up until the CPU posts its next word. The CPU gets a receive-full interrupt and a transmit-empty interrupt, each gated by its own enable. The host gets one interrupt line that follows the outbound flag when its route enable is set. The host can also read a status word carrying both pending flags.

Top module: `host_cpu_mailbox`

## Requirements
- R1: After reset, both pending flags, the transmit-empty condition, all three interrupt outputs and both mailbox readback words are zero.
- R2: A host write with the status select low stores the word. On the following cycle the CPU read data shows that word and the inbound pending flag is 1. `cpu_rx_full_irq_o` then equals `cpu_rx_irq_en_i`.
- R3: A CPU read strobe clears the inbound pending flag on the next cycle unless a host mailbox write occurs in the same cycle.
- R4: A CPU write stores the word and sets the outbound pending flag on the next cycle. `host_irq_o` is 1 exactly when the outbound flag is 1 and `host_irq_en_i` is 1.
- R5: A host read with the status select low returns the CPU's word. It clears the outbound flag on the next cycle and sets the transmit-empty condition. `cpu_tx_empty_irq_o` equals that condition ANDed with `cpu_tx_irq_en_i`.
- R6: A CPU write clears the transmit-empty condition on the next cycle unless a host mailbox read occurs in the same cycle.
- R7: The two directions hold separate words: a write from one side never changes the word readable by that same side.
- R8: A second write before the reader collects the word replaces it and leaves the pending flag at 1.
- R9: When a flag is set and cleared in the same cycle it ends up set, and the CPU read in that cycle sees the old word.
- R10: A host read or write with the status select high changes no flag and no stored word.
- R11: The host status word (status select high) has bit 0 = outbound pending, bit 1 = inbound pending, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_stat_sel_i | input | 1 | 0 selects the mailbox, 1 selects the status word |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (mailbox or status) |
| cpu_wr_i | input | 1 | CPU mailbox write strobe |
| cpu_rd_i | input | 1 | CPU mailbox read strobe |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_rdata_o | output | 16 | Word posted by the host |
| cpu_rx_irq_en_i | input | 1 | Enable for the receive-full interrupt |
| cpu_tx_irq_en_i | input | 1 | Enable for the transmit-empty interrupt |
| host_irq_en_i | input | 1 | Route enable for the host interrupt |
| cpu_rx_full_irq_o | output | 1 | Receive-full interrupt to the CPU |
| cpu_tx_empty_irq_o | output | 1 | Transmit-empty interrupt to the CPU |
| host_irq_o | output | 1 | Interrupt line to the host |
| in_pending_o | output | 1 | Inbound (host to CPU) pending flag |
| out_pending_o | output | 1 | Outbound (CPU to host) pending flag |

## Verification
The hardest cases are the ones where a flag is set and cleared on the same edge. Examples are a host write landing in the same cycle as a CPU read, and a CPU write landing in the same cycle as a host read. Ordinary traffic with idle gaps never produces them. The stimulus table drives both sides' strobes in one vector, so these collisions are hit deliberately. The table also drives status-select accesses between normal ones, to show they leave all state alone.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    parameter int unsigned MBOX_DW = 16;

    localparam int unsigned STAT_OUT_BIT = 0;
    localparam int unsigned STAT_IN_BIT  = 1;

    typedef enum logic [1:0] {
        HACC_IDLE    = 2'd0,
        HACC_WR_MBOX = 2'd1,
        HACC_RD_MBOX = 2'd2,
        HACC_RD_STAT = 2'd3
    } hacc_e;

endpackage

// File: rtl/mbox_flag.sv
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] data_o,
    output logic          full_o
);
    typedef struct packed {
        logic [DW-1:0] word;
    } chan_t;

    chan_t chan_d, chan_q;

    always_comb begin
        chan_d = chan_q;
        if (wr_i) chan_d.word = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    mbox_flag u_full (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_i),
        .clr_i  (rd_i),
        .flag_o (full_o)
    );

    assign data_o = chan_q.word;

    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (chan_q.word == $past(wdata_i)));
    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(chan_q.word));

endmodule

// File: rtl/mbox_host_port.sv
module mbox_host_port
    import mbox_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          host_wr_i,
    input  logic          host_rd_i,
    input  logic          host_stat_sel_i,
    input  logic [DW-1:0] out_word_i,
    input  logic          out_pending_i,
    input  logic          in_pending_i,
    output logic          mbox_wr_o,
    output logic          mbox_rd_o,
    output logic [DW-1:0] host_rdata_o
);
    hacc_e         acc;
    logic [DW-1:0] stat_word;

    // A write takes priority over a read strobed in the same cycle;
    // a write aimed at the status word is dropped.
    always_comb begin
        acc = HACC_IDLE;
        if (host_wr_i) begin
            if (!host_stat_sel_i) acc = HACC_WR_MBOX;
        end else if (host_rd_i) begin
            acc = host_stat_sel_i ? HACC_RD_STAT : HACC_RD_MBOX;
        end
    end

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_OUT_BIT] = out_pending_i;
        stat_word[STAT_IN_BIT]  = in_pending_i;
    end

    assign mbox_wr_o    = (acc == HACC_WR_MBOX);
    assign mbox_rd_o    = (acc == HACC_RD_MBOX);
    assign host_rdata_o = host_stat_sel_i ? stat_word : out_word_i;

    always_comb begin
        if (host_stat_sel_i) begin
            a_stat_no_side_r10: assert (!mbox_wr_o && !mbox_rd_o);
        end
    end

endmodule

// File: rtl/host_cpu_mailbox.sv
module host_cpu_mailbox
    import mbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_i,
    input  logic               host_rd_i,
    input  logic               host_stat_sel_i,
    input  logic [MBOX_DW-1:0] host_wdata_i,
    output logic [MBOX_DW-1:0] host_rdata_o,
    input  logic               cpu_wr_i,
    input  logic               cpu_rd_i,
    input  logic [MBOX_DW-1:0] cpu_wdata_i,
    output logic [MBOX_DW-1:0] cpu_rdata_o,
    input  logic               cpu_rx_irq_en_i,
    input  logic               cpu_tx_irq_en_i,
    input  logic               host_irq_en_i,
    output logic               cpu_rx_full_irq_o,
    output logic               cpu_tx_empty_irq_o,
    output logic               host_irq_o,
    output logic               in_pending_o,
    output logic               out_pending_o
);
    logic               h_mbox_wr, h_mbox_rd;
    logic               in_full, out_full, tx_empty;
    logic [MBOX_DW-1:0] out_word;

    mbox_host_port #(.DW(MBOX_DW)) u_hport (
        .host_wr_i       (host_wr_i),
        .host_rd_i       (host_rd_i),
        .host_stat_sel_i (host_stat_sel_i),
        .out_word_i      (out_word),
        .out_pending_i   (out_full),
        .in_pending_i    (in_full),
        .mbox_wr_o       (h_mbox_wr),
        .mbox_rd_o       (h_mbox_rd),
        .host_rdata_o    (host_rdata_o)
    );

    // host -> CPU direction
    mbox_channel #(.DW(MBOX_DW)) u_inbound (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (h_mbox_wr),
        .wdata_i (host_wdata_i),
        .rd_i    (cpu_rd_i),
        .data_o  (cpu_rdata_o),
        .full_o  (in_full)
    );

    // CPU -> host direction
    mbox_channel #(.DW(MBOX_DW)) u_outbound (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cpu_wr_i),
        .wdata_i (cpu_wdata_i),
        .rd_i    (h_mbox_rd),
        .data_o  (out_word),
        .full_o  (out_full)
    );

    // transmit-empty: raised by the host collecting, dropped by the CPU posting
    mbox_flag u_tx_empty (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (h_mbox_rd),
        .clr_i  (cpu_wr_i),
        .flag_o (tx_empty)
    );

    assign cpu_rx_full_irq_o  = in_full  & cpu_rx_irq_en_i;
    assign cpu_tx_empty_irq_o = tx_empty & cpu_tx_irq_en_i;
    assign host_irq_o         = out_full & host_irq_en_i;
    assign in_pending_o       = in_full;
    assign out_pending_o      = out_full;

    p_rx_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && !host_stat_sel_i) |=> (cpu_rx_full_irq_o == cpu_rx_irq_en_i));
    p_host_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_i |=> (host_irq_o == host_irq_en_i));
    p_tx_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_i && !host_wr_i && !host_stat_sel_i) |=>
            (!out_pending_o || $past(cpu_wr_i)) && (cpu_tx_empty_irq_o == cpu_tx_irq_en_i));
    p_tx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !(host_rd_i && !host_wr_i && !host_stat_sel_i)) |=> !cpu_tx_empty_irq_o);

endmodule

// File: tb/host_cpu_mailbox_tb_top.sv
module host_cpu_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd, host_sel;
    logic [15:0] host_wdata, host_rdata;
    logic        cpu_wr, cpu_rd;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic        rx_en, tx_en, h_en;
    logic        rx_irq, tx_irq, h_irq, in_p, out_p;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    host_cpu_mailbox dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .host_wr_i          (host_wr),
        .host_rd_i          (host_rd),
        .host_stat_sel_i    (host_sel),
        .host_wdata_i       (host_wdata),
        .host_rdata_o       (host_rdata),
        .cpu_wr_i           (cpu_wr),
        .cpu_rd_i           (cpu_rd),
        .cpu_wdata_i        (cpu_wdata),
        .cpu_rdata_o        (cpu_rdata),
        .cpu_rx_irq_en_i    (rx_en),
        .cpu_tx_irq_en_i    (tx_en),
        .host_irq_en_i      (h_en),
        .cpu_rx_full_irq_o  (rx_irq),
        .cpu_tx_empty_irq_o (tx_irq),
        .host_irq_o         (h_irq),
        .in_pending_o       (in_p),
        .out_pending_o      (out_p)
    );

    typedef struct packed {
        logic        hw, hr, hs;
        logic [15:0] hd;
        logic        cw, cr;
        logic [15:0] cd;
        logic        ein, eout, etxe;
        logic [15:0] ecpu, ehost;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,16'hA001, 1'b0,1'b0,16'h0000, 1'b1,1'b0,1'b0, 16'hA001,16'h0000, 4'd2},  // R2
        '{1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1,16'h0000, 1'b0,1'b0,1'b0, 16'hA001,16'h0000, 4'd3},  // R3
        '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0,16'hB001, 1'b0,1'b1,1'b0, 16'hA001,16'hB001, 4'd4},  // R4
        '{1'b0,1'b1,1'b1,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,1'b1,1'b0, 16'hA001,16'hB001, 4'd10}, // R10
        '{1'b1,1'b0,1'b1,16'hFFFF, 1'b0,1'b0,16'h0000, 1'b0,1'b1,1'b0, 16'hA001,16'hB001, 4'd10}, // R10
        '{1'b0,1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b1, 16'hA001,16'hB001, 4'd5},  // R5
        '{1'b1,1'b0,1'b0,16'hA002, 1'b1,1'b0,16'hB002, 1'b1,1'b1,1'b0, 16'hA002,16'hB002, 4'd7},  // R7
        '{1'b1,1'b0,1'b0,16'hA003, 1'b0,1'b0,16'h0000, 1'b1,1'b1,1'b0, 16'hA003,16'hB002, 4'd8},  // R8
        '{1'b1,1'b0,1'b0,16'hA004, 1'b0,1'b1,16'h0000, 1'b1,1'b1,1'b0, 16'hA004,16'hB002, 4'd9},  // R9
        '{1'b0,1'b1,1'b0,16'h0000, 1'b1,1'b0,16'hB003, 1'b1,1'b1,1'b1, 16'hA004,16'hB003, 4'd9},  // R9
        '{1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0,16'hB004, 1'b1,1'b1,1'b0, 16'hA004,16'hB004, 4'd6},  // R6
        '{1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1,16'h0000, 1'b0,1'b1,1'b0, 16'hA004,16'hB004, 4'd3},  // R3
        '{1'b0,1'b1,1'b0,16'h0000, 1'b0,1'b0,16'h0000, 1'b0,1'b0,1'b1, 16'hA004,16'hB004, 4'd5}   // R5
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        host_wr = 0; host_rd = 0; host_sel = 0; host_wdata = '0;
        cpu_wr  = 0; cpu_rd  = 0; cpu_wdata = '0;
    endtask

    // Drive one access cycle, then return with strobes low, just after the edge.
    task automatic access(input logic hw, hr, hs, input logic [15:0] hd,
                          input logic cw, cr, input logic [15:0] cd);
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_sel = hs; host_wdata = hd;
        cpu_wr  = cw; cpu_rd  = cr; cpu_wdata = cd;
        @(negedge clk);
        idle_inputs();
        #1;
    endtask

    task automatic check_reset_state(input string tag);
        check(tag, "in_pending", {15'd0, in_p}, 16'd0);
        check(tag, "out_pending", {15'd0, out_p}, 16'd0);
        check(tag, "irqs", {13'd0, rx_irq, tx_irq, h_irq}, 16'd0);
        check(tag, "cpu_rdata", cpu_rdata, 16'd0);
        check(tag, "host_rdata", host_rdata, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rx_en = 1; tx_en = 1; h_en = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check_reset_state("R1");

        for (int i = 0; i < NV; i++) begin
            string tag;
            vec_t  v;
            v = VECS[i];
            tag = $sformatf("R%0d v%0d", v.req, i);
            access(v.hw, v.hr, v.hs, v.hd, v.cw, v.cr, v.cd);
            check(tag, "in_pending", {15'd0, in_p}, {15'd0, v.ein});
            check(tag, "out_pending", {15'd0, out_p}, {15'd0, v.eout});
            check(tag, "rx_irq", {15'd0, rx_irq}, {15'd0, v.ein});
            check(tag, "host_irq", {15'd0, h_irq}, {15'd0, v.eout});
            check(tag, "tx_irq", {15'd0, tx_irq}, {15'd0, v.etxe});
            check(tag, "cpu_rdata", cpu_rdata, v.ecpu);
            check(tag, "host_rdata", host_rdata, v.ehost);
        end

        // R2 gating and R11 status layout: inbound pending only
        rx_en = 0;
        access(1, 0, 0, 16'hC001, 0, 0, 16'h0);
        check("R2", "rx_irq gated", {15'd0, rx_irq}, 16'd0);
        check("R2", "in_pending", {15'd0, in_p}, 16'd1);
        host_sel = 1; #1;
        check("R11", "status in only", host_rdata, 16'h0002);
        host_sel = 0;
        rx_en = 1; #1;
        check("R2", "rx_irq enabled", {15'd0, rx_irq}, 16'd1);

        // R4 route gating and R11 both bits
        h_en = 0;
        access(0, 0, 0, 16'h0, 1, 0, 16'hD001);
        check("R4", "host_irq gated", {15'd0, h_irq}, 16'd0);
        host_sel = 1; #1;
        check("R11", "status both", host_rdata, 16'h0003);
        host_sel = 0; h_en = 1; #1;
        check("R4", "host_irq routed", {15'd0, h_irq}, 16'd1);

        // R5 transmit-empty gating
        tx_en = 0;
        access(0, 1, 0, 16'h0, 0, 0, 16'h0);
        check("R5", "tx_irq gated", {15'd0, tx_irq}, 16'd0);
        check("R5", "out cleared", {15'd0, out_p}, 16'd0);
        tx_en = 1; #1;
        check("R5", "tx_irq enabled", {15'd0, tx_irq}, 16'd1);
        host_sel = 1; #1;
        check("R11", "status in only again", host_rdata, 16'h0002);
        host_sel = 0;

        // R1: reset mid-run returns everything to zero
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        check_reset_state("R1");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule